// File: doc/BRIEF.md
# PHY Link Request Handler

This block sits on the physical-layer side of a serial-bus PHY/link interface. It takes requests that a deserializer has already decoded from the link-layer controller and acts on them. There are register writes, register reads and four classes of bus-arbitration request. The block keeps a small PHY register file. A write updates one entry. A read starts a return of one entry's contents, which an external status serializer carries out.

At most one bus request is pending at a time. Any other request that arrives while one is pending is dropped. Each request class has its own condition for retiring the pending request: packet activity in either direction, a subaction gap for the isochronous and immediate classes only, or a bus reset. Accepting an isochronous request also raises a sticky flag that selects accelerated arbitration.

Top module: `phy_req_handler`

## Requirements
- R1: After rst_n is released, pend_valid, accel, ret_start, ret_busy and read_clash are all 0, and every register entry reads back as 0.
- R2: A request with req_kind 3'd0 (write) is applied when its req_valid strobe marks the end of reception. Any later read of that address returns the written byte.
- R3: A request with req_kind 3'd1 (read) that arrives while ret_busy is 0 causes the following:
  - ret_start is high for exactly one cycle after the edge that takes the request.
  - ret_addr and ret_data then hold the address and that entry's contents.
  - ret_busy stays 1 until an edge at which ret_done is 1.
- R4: A read that arrives while ret_busy is 1 causes no ret_start, leaves ret_addr and ret_data unchanged, and pulses read_clash for one cycle.
- R5: A bus request is taken when no request is pending. The bus request codes are req_kind 3'd4 fair, 3'd5 priority, 3'd6 isochronous and 3'd7 immediate. After the edge, pend_valid is 1 and pend_class holds the low two bits of the kind: 00 fair, 01 priority, 10 isochronous, 11 immediate.
- R6: While pend_valid is 1, any further bus request is ignored and pend_class keeps its value.
- R7: pkt_rx or pkt_tx high while a request is pending clears pend_valid at that edge, whatever the class.
- R8: subgap clears a pending isochronous or immediate request. It has no effect on a pending fair or priority request.
- R9: bus_reset clears pend_valid and accel at that edge. A bus request presented in the same cycle is dropped.
- R10: Taking an isochronous request sets accel. accel stays 1 until a bus reset.
- R11: req_kind 3'd2 and 3'd3 are reserved. They change neither the register file, the pending request nor the return outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle strobe: a decoded request is complete |
| req_kind | input | 3 | Request type code |
| req_addr | input | AW | Register address |
| req_data | input | DW | Write data |
| pkt_rx | input | 1 | A packet is being received |
| pkt_tx | input | 1 | A packet is being transmitted |
| subgap | input | 1 | Subaction gap detected |
| bus_reset | input | 1 | Bus reset in progress |
| ret_done | input | 1 | The status serializer finished the current return |
| pend_valid | output | 1 | A bus request is pending |
| pend_class | output | 2 | Class of the pending bus request |
| accel | output | 1 | Accelerated arbitration enabled |
| ret_start | output | 1 | One-cycle command to start a register return |
| ret_addr | output | AW | Address being returned |
| ret_data | output | DW | Contents being returned |
| ret_busy | output | 1 | A register return is in progress |
| read_clash | output | 1 | A read arrived while a return was in progress |

## Verification
The case that is hardest to reach from the ports is a bus request that collides with a retire condition. Examples are a subaction gap during a fair request, or a new request in the same cycle as a bus reset or a packet cancel. A second read landing just before or exactly on the ret_done edge is equally hard. Random stimulus keeps cancel and done events rare, so that requests stay pending long enough to be hit by the competing traffic. Directed sequences then place each collision on a chosen edge.

// File: rtl/phy_req_handler.sv
`timescale 1ns/1ps
module phy_req_handler #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic          pkt_rx,
  input  logic          pkt_tx,
  input  logic          subgap,
  input  logic          bus_reset,
  input  logic          ret_done,
  output logic          pend_valid,
  output logic [1:0]    pend_class,
  output logic          accel,
  output logic          ret_start,
  output logic [AW-1:0] ret_addr,
  output logic [DW-1:0] ret_data,
  output logic          ret_busy,
  output logic          read_clash
);
  localparam int NREG = 1 << AW;
  localparam logic [2:0] K_WR = 3'd0;
  localparam logic [2:0] K_RD = 3'd1;
  localparam logic [1:0] C_ISO = 2'b10;

  logic [DW-1:0] regs [NREG];

  wire is_wr  = req_valid && (req_kind == K_WR);
  wire is_rd  = req_valid && (req_kind == K_RD);
  wire is_bus = req_valid && req_kind[2];
  wire cancel = pkt_rx || pkt_tx || (subgap && pend_class[1]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (is_wr) begin
      regs[req_addr] <= req_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_class <= '0;
      accel      <= 1'b0;
    end else if (bus_reset) begin
      pend_valid <= 1'b0;
      accel      <= 1'b0;
    end else if (pend_valid) begin
      if (cancel) pend_valid <= 1'b0;
    end else if (is_bus) begin
      pend_valid <= 1'b1;
      pend_class <= req_kind[1:0];
      if (req_kind[1:0] == C_ISO) accel <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ret_start  <= 1'b0;
      ret_busy   <= 1'b0;
      read_clash <= 1'b0;
      ret_addr   <= '0;
      ret_data   <= '0;
    end else begin
      ret_start  <= 1'b0;
      read_clash <= 1'b0;
      if (ret_done) ret_busy <= 1'b0;
      if (is_rd) begin
        if (ret_busy) begin
          read_clash <= 1'b1;
        end else begin
          ret_start <= 1'b1;
          ret_busy  <= 1'b1;
          ret_addr  <= req_addr;
          ret_data  <= regs[req_addr];
        end
      end
    end
  end
endmodule

// File: rtl/phy_req_handler_chk.sv
`timescale 1ns/1ps
module phy_req_handler_chk #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [2:0]    req_kind,
  input logic          pkt_rx,
  input logic          pkt_tx,
  input logic          subgap,
  input logic          bus_reset,
  input logic          pend_valid,
  input logic [1:0]    pend_class,
  input logic          accel,
  input logic          ret_start,
  input logic [AW-1:0] ret_addr,
  input logic [DW-1:0] ret_data,
  input logic          ret_busy,
  input logic          read_clash
);
  a_r6_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid && !pkt_rx && !pkt_tx && !subgap && !bus_reset |=> pend_valid && $stable(pend_class));
  a_r7_packet_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid && (pkt_rx || pkt_tx) && !bus_reset |=> !pend_valid);
  a_r8_gap_keeps_fair: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid && !pend_class[1] && !pkt_rx && !pkt_tx && !bus_reset |=> pend_valid);
  a_r9_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> !pend_valid && !accel);
  a_r4_clash: assert property (@(posedge clk) disable iff (!rst_n)
    ret_busy && req_valid && req_kind == 3'd1 |=> read_clash && !ret_start && $stable(ret_data) && $stable(ret_addr));
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ret_start |=> !ret_start);
  a_r3_busy_with_start: assert property (@(posedge clk) disable iff (!rst_n)
    ret_start |-> ret_busy);
  a_r10_accel_from_iso: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(accel) |-> pend_valid && pend_class == 2'b10);
endmodule

bind phy_req_handler phy_req_handler_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
  .pkt_rx(pkt_rx), .pkt_tx(pkt_tx), .subgap(subgap), .bus_reset(bus_reset),
  .pend_valid(pend_valid), .pend_class(pend_class), .accel(accel),
  .ret_start(ret_start), .ret_addr(ret_addr), .ret_data(ret_data),
  .ret_busy(ret_busy), .read_clash(read_clash)
);

// File: tb/phy_req_handler_tb_top.sv
`timescale 1ns/1ps
module phy_req_handler_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_kind = '0;
  logic [3:0] req_addr = '0;
  logic [7:0] req_data = '0;
  logic pkt_rx = 1'b0, pkt_tx = 1'b0, subgap = 1'b0, bus_reset = 1'b0, ret_done = 1'b0;
  logic pend_valid, accel, ret_start, ret_busy, read_clash;
  logic [1:0] pend_class;
  logic [3:0] ret_addr;
  logic [7:0] ret_data;

  int vectors = 0;
  int misses = 0;
  bit finished = 0;

  logic [7:0] m_regs [16];
  logic m_pv = 0, m_acc = 0, m_busy = 0, m_start = 0, m_clash = 0;
  logic [1:0] m_pc = 0;
  logic [3:0] m_raddr = 0;
  logic [7:0] m_rdata = 0;

  always #2 clk = ~clk;

  phy_req_handler dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_data(req_data), .pkt_rx(pkt_rx), .pkt_tx(pkt_tx),
    .subgap(subgap), .bus_reset(bus_reset), .ret_done(ret_done),
    .pend_valid(pend_valid), .pend_class(pend_class), .accel(accel),
    .ret_start(ret_start), .ret_addr(ret_addr), .ret_data(ret_data),
    .ret_busy(ret_busy), .read_clash(read_clash)
  );

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic gap_cancels(logic [1:0] c);
    return c[1];
  endfunction

  task automatic model_edge();
    logic wr, rd, bus;
    wr = req_valid && req_kind == 3'd0;
    rd = req_valid && req_kind == 3'd1;
    bus = req_valid && req_kind[2];
    if (wr) m_regs[req_addr] = req_data;
    m_start = 0;
    m_clash = 0;
    if (rd) begin
      if (m_busy) m_clash = 1;
      else begin
        m_start = 1;
        m_raddr = req_addr;
        m_rdata = m_regs[req_addr];
      end
    end
    if (ret_done) m_busy = 0;
    if (rd && !m_clash) m_busy = 1;
    if (bus_reset) begin
      m_pv = 0;
      m_acc = 0;
    end else if (m_pv) begin
      if (pkt_rx || pkt_tx || (subgap && gap_cancels(m_pc))) m_pv = 0;
    end else if (bus) begin
      m_pv = 1;
      m_pc = req_kind[1:0];
      if (req_kind[1:0] == 2'b10) m_acc = 1;
    end
  endtask

  task automatic compare_all();
    check("R3 ret_start", 16'(ret_start), 16'(m_start));
    check("R3 ret_busy", 16'(ret_busy), 16'(m_busy));
    check("R4 read_clash", 16'(read_clash), 16'(m_clash));
    check("R5 pend_valid", 16'(pend_valid), 16'(m_pv));
    if (m_pv) check("R6 pend_class", 16'(pend_class), 16'(m_pc));
    check("R10 accel", 16'(accel), 16'(m_acc));
    if (m_start) begin
      check("R2 ret_data", 16'(ret_data), 16'(m_rdata));
      check("R3 ret_addr", 16'(ret_addr), 16'(m_raddr));
    end
  endtask

  task automatic step(logic v, logic [2:0] k, logic [3:0] a, logic [7:0] d,
                      logic rx, logic tx, logic g, logic br, logic dn);
    @(negedge clk);
    req_valid = v; req_kind = k; req_addr = a; req_data = d;
    pkt_rx = rx; pkt_tx = tx; subgap = g; bus_reset = br; ret_done = dn;
    @(posedge clk);
    model_edge();
    #1;
    compare_all();
  endtask

  task automatic idle();
    step(0, 3'd0, 4'd0, 8'd0, 0, 0, 0, 0, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    misses++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int seed;
    logic [7:0] keep;
    seed = 32'h1394;
    void'($urandom(seed));
    for (int i = 0; i < 16; i++) m_regs[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1 pend_valid", 16'(pend_valid), 16'd0);
    check("R1 accel", 16'(accel), 16'd0);
    check("R1 ret_busy", 16'(ret_busy), 16'd0);
    check("R1 read_clash", 16'(read_clash), 16'd0);
    step(1, 3'd1, 4'd9, 8'd0, 0, 0, 0, 0, 0);
    check("R1 reg zero", 16'(ret_data), 16'd0);
    step(0, 3'd0, 4'd0, 8'd0, 0, 0, 0, 0, 1);

    // R2 write then read back
    step(1, 3'd0, 4'd5, 8'hA7, 0, 0, 0, 0, 0);
    step(1, 3'd1, 4'd5, 8'd0, 0, 0, 0, 0, 0);
    check("R2 readback", 16'(ret_data), 16'h00A7);
    // R4 second read while busy, then one on the done edge
    step(1, 3'd1, 4'd0, 8'd0, 0, 0, 0, 0, 0);
    check("R4 clash flag", 16'(read_clash), 16'd1);
    step(1, 3'd1, 4'd0, 8'd0, 0, 0, 0, 0, 1);
    idle();

    // R8 subgap spares fair, retires iso
    step(1, 3'd4, 4'd0, 8'd0, 0, 0, 0, 0, 0);
    step(0, 3'd0, 4'd0, 8'd0, 0, 0, 1, 0, 0);
    check("R8 fair kept", 16'(pend_valid), 16'd1);
    // R6 other request ignored
    step(1, 3'd7, 4'd0, 8'd0, 0, 0, 0, 0, 0);
    check("R6 class kept", 16'(pend_class), 16'd0);
    // R7 packet cancel with competing request
    step(1, 3'd5, 4'd0, 8'd0, 0, 1, 0, 0, 0);
    check("R7 cancelled", 16'(pend_valid), 16'd0);
    step(1, 3'd6, 4'd0, 8'd0, 0, 0, 0, 0, 0);
    check("R10 accel set", 16'(accel), 16'd1);
    step(0, 3'd0, 4'd0, 8'd0, 0, 0, 1, 0, 0);
    check("R8 iso retired", 16'(pend_valid), 16'd0);
    check("R10 accel sticky", 16'(accel), 16'd1);
    // R9 bus reset drops same-cycle request
    step(1, 3'd7, 4'd0, 8'd0, 0, 0, 0, 1, 0);
    check("R9 pend cleared", 16'(pend_valid), 16'd0);
    check("R9 accel cleared", 16'(accel), 16'd0);
    // R11 reserved kinds
    step(1, 3'd2, 4'd5, 8'h11, 0, 0, 0, 0, 0);
    step(1, 3'd3, 4'd5, 8'h22, 0, 0, 0, 0, 0);
    check("R11 no pend", 16'(pend_valid), 16'd0);
    step(1, 3'd1, 4'd5, 8'd0, 0, 0, 0, 0, 0);
    check("R11 reg intact", 16'(ret_data), 16'h00A7);
    step(0, 3'd0, 4'd0, 8'd0, 0, 0, 0, 0, 1);

    for (int n = 0; n < 3000; n++) begin
      keep = 8'($urandom);
      step(keep[0] | keep[1], 3'($urandom), 4'($urandom), 8'($urandom),
           ($urandom % 12) == 0, ($urandom % 12) == 0, ($urandom % 6) == 0,
           ($urandom % 40) == 0, m_busy && (($urandom % 5) == 0));
    end
    finish_run();
  end
endmodule